// File: doc/BRIEF.md
# DAC Playback Sample FIFO Controller

This block feeds a stereo 16-bit DAC datapath from a 32-bit register bus. Software, or a DMA engine driven by the block's request line, writes sample words into a transmit-data register. The block keeps one 16-bit sample per written word in a 64-entry FIFO. A control register selects the output sample rate, which half of each word carries the sample, mono or stereo operation, a free-space threshold and a hold-off count for the DMA request, and a request enable. Writing the control register with its flush bit set empties the FIFO, which is how a stream is prepared before it starts.

The whole block runs from a fixed 24.576 MHz audio clock. A divider turns that clock into a sample-rate strobe. Rates of the 44.1 kHz family cannot be derived from it, so the block offers none. On each strobe the block pops either one sample, which drives both DAC channels, or a left sample followed by a right one. If the FIFO cannot supply them, the DAC keeps its previous values and a sticky underrun flag is raised. The status register reports that flag and the number of free FIFO entries.

Top module: `dac_play_fifo`

## Requirements
- R1: After reset every output is zero, the control register reads 0, the underrun flag is 0 and the free count is 64.
- R2: The register select codes are 0 for control, 1 for status and 2 for transmit data. The control register reads back rate code in [31:29], packing mode in [25:24], request hold-off count in [22:21], request threshold in [14:8], mono in bit 6, width select in bit 5 and request enable in bit 4. Bit 0 (flush) always reads 0 and all other bits read 0.
- R3: Rate codes 0..7 mean 48, 32, 24, 16, 12, 8, 192 and 96 kHz. The strobe (dac_valid one cycle later) fires every 24576000/fs clock cycles. A control write restarts the divider, so the first output follows 24576000/fs cycles after that write.
- R4: A transmit-data write stores bits [15:0] when the packing mode is 1 and bits [31:16] for any other mode value.
- R5: In stereo mode each strobe pops two samples, the older to dac_left and the newer to dac_right. In mono mode each strobe pops one sample and drives it to both outputs.
- R6: A strobe that finds fewer samples than it needs pops nothing, leaves both outputs unchanged and sets the underrun flag (status bit 0).
- R7: Writing the status register with bit 0 set clears the underrun flag, and writing it with bit 0 clear leaves the flag unchanged. A new underrun in the same cycle takes priority over the clear.
- R8: A control write with bit 0 set empties the FIFO, so the free count reads 64 afterwards.
- R9: dma_req is high exactly when the request enable is set, the free count is greater than or equal to the threshold, and the hold-off is zero. Each transmit-data write loads the hold-off with count+1, and each strobe decrements it. A control write clears it, and writing zero to the control register stops requests.
- R10: The FIFO holds 64 samples. A transmit-data write to a full FIFO is dropped and the stored samples are unaffected.
- R11: The status register reads the free count in [22:16], the underrun flag in bit 0 and 0 elsewhere. Select 2 and select 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 transmit data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| dac_left | output | 16 | Left sample to the DAC |
| dac_right | output | 16 | Right sample to the DAC |
| dac_valid | output | 1 | One-cycle pulse when new DAC values are presented |
| dma_req | output | 1 | DMA request for more samples |

## Verification
The properties assume that each bus write lasts a single cycle with a stable select and data. They also assume the rate code changes only through a control write, because the divider restart rests on that. The stimulus drives every register access on the falling clock edge for exactly one cycle. It interleaves sample writes, flushes and status writes with strobes at several rates. It fills the FIFO past its depth while the slowest rate keeps strobes away, so the drop on a full FIFO is seen at the outputs once the FIFO drains.

// File: rtl/dac_pf_pkg.sv
package dac_pf_pkg;

   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_TXD  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // control field positions (software-visible layout)
   localparam int RATE_LSB  = 29;
   localparam int PACK_LSB  = 24;
   localparam int HOLD_LSB  = 21;
   localparam int TRIG_LSB  = 8;
   localparam int MONO_BIT  = 6;
   localparam int WIDE_BIT  = 5;
   localparam int REQEN_BIT = 4;
   localparam int FLUSH_BIT = 0;

   // status field positions
   localparam int UNDER_BIT = 0;
   localparam int FREE_LSB  = 16;
   localparam int FREE_W    = 7;

   localparam logic [1:0] PACK_LOW_HALF = 2'd1;

   typedef struct packed {
      logic [2:0] rate;
      logic [1:0] pack;
      logic [1:0] hold_cnt;
      logic [6:0] trig;
      logic       mono;
      logic       wide;
      logic       req_en;
   } ctrl_t;

   function automatic int unsigned rate_hz(input logic [2:0] code);
      case (code)
         3'd0:    return 48000;
         3'd1:    return 32000;
         3'd2:    return 24000;
         3'd3:    return 16000;
         3'd4:    return 12000;
         3'd5:    return 8000;
         3'd6:    return 192000;
         default: return 96000;
      endcase
   endfunction

   function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
      ctrl_t c;
      c.rate     = w[RATE_LSB +: 3];
      c.pack     = w[PACK_LSB +: 2];
      c.hold_cnt = w[HOLD_LSB +: 2];
      c.trig     = w[TRIG_LSB +: 7];
      c.mono     = w[MONO_BIT];
      c.wide     = w[WIDE_BIT];
      c.req_en   = w[REQEN_BIT];
      return c;
   endfunction

   function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
      logic [REG_W-1:0] w;
      w = '0;
      w[RATE_LSB +: 3] = c.rate;
      w[PACK_LSB +: 2] = c.pack;
      w[HOLD_LSB +: 2] = c.hold_cnt;
      w[TRIG_LSB +: 7] = c.trig;
      w[MONO_BIT]      = c.mono;
      w[WIDE_BIT]      = c.wide;
      w[REQEN_BIT]     = c.req_en;
      return w;
   endfunction

endpackage

// File: rtl/dac_pf_rate_gen.sv
module dac_pf_rate_gen
   import dac_pf_pkg::*;
#(
   parameter int unsigned CLK_HZ = 24576000,
   parameter int          DIV_W  = 12
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] rate_code,
   input  logic       restart,
   output logic       strobe
);

   logic [DIV_W-1:0] last_tab [8];
   logic [DIV_W-1:0] cnt_q;

   // one terminal count per rate code, folded at elaboration
   for (genvar g = 0; g < 8; g++) begin : g_rate
      assign last_tab[g] = DIV_W'(CLK_HZ / rate_hz(3'(g)) - 1);
   end

   assign strobe = (cnt_q == last_tab[rate_code]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || strobe) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/dac_pf_store.sv
module dac_pf_store #(
   parameter  int DEPTH = 64,
   parameter  int W     = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic [1:0]    pop_n,
   output logic [W-1:0]  head0,
   output logic [W-1:0]  head1,
   output logic [CW-1:0] fill
);

   logic [AW-1:0]             wr_ptr, rd_ptr;
   logic [CW-1:0]             fill_q;
   logic                      push_ok;
   logic [DEPTH-1:0][W-1:0]   cells;

   assign push_ok = push && (fill_q != CW'(DEPTH));

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (push_ok && (wr_ptr == AW'(g))) begin
            cell_q <= push_data;
         end
      end
      assign cells[g] = cell_q;
   end

   assign head0 = cells[rd_ptr];
   assign head1 = cells[rd_ptr + AW'(1)];
   assign fill  = fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill_q <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill_q <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(push_ok);
         rd_ptr <= rd_ptr + AW'(pop_n);
         fill_q <= fill_q + CW'(push_ok) - CW'(pop_n);
      end
   end

endmodule

// File: rtl/dac_pf_req.sv
module dac_pf_req #(
   parameter int CW = 7
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_write,
   input  logic          cfg_write,
   input  logic          strobe,
   input  logic [1:0]    hold_cnt,
   input  logic          req_en,
   input  logic [6:0]    trig,
   input  logic [CW-1:0] free_cnt,
   output logic          req
);

   logic [2:0] hold_q;
   logic       room_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (cfg_write) begin
         hold_q <= '0;
      end else if (tx_write) begin
         hold_q <= {1'b0, hold_cnt} + 3'd1;
      end else if (strobe && (hold_q != 3'd0)) begin
         hold_q <= hold_q - 3'd1;
      end
   end

   assign room_ok = (int'(free_cnt) >= int'(trig));
   assign req     = req_en && room_ok && (hold_q == 3'd0);

endmodule

// File: rtl/dac_play_fifo.sv
module dac_play_fifo
   import dac_pf_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 24576000,
   parameter int          DEPTH    = 64,
   parameter int          SAMPLE_W = 16
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [1:0]          reg_sel,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic [SAMPLE_W-1:0] dac_left,
   output logic [SAMPLE_W-1:0] dac_right,
   output logic                dac_valid,
   output logic                dma_req
);

   localparam int AW    = $clog2(DEPTH);
   localparam int CW    = AW + 1;
   localparam int DIV_W = $clog2(CLK_HZ / 8000 + 1);

   initial begin : param_chk
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH >= (1 << FREE_W))
         $fatal(1, "DEPTH must be a power of two that fits the free-count field");
      if (SAMPLE_W < 1 || SAMPLE_W > 16)
         $fatal(1, "SAMPLE_W must lie in 1..16");
      if ((CLK_HZ % 192000) != 0 || (CLK_HZ % 32000) != 0 || (CLK_HZ % 12000) != 0)
         $fatal(1, "CLK_HZ must divide evenly into every supported rate");
   end

   ctrl_t               ctrl_q;
   logic                underrun_q;
   logic                rate_strobe;
   logic                req_en;
   logic                wr_ctrl, wr_stat, wr_txd, flush_pulse;
   logic [15:0]         half_sel;
   logic [SAMPLE_W-1:0] push_sample;
   logic [SAMPLE_W-1:0] head0, head1;
   logic [CW-1:0]       fill, free_cnt;
   logic [1:0]          need, pop_n;
   logic                pop_ok, under_set;

   assign wr_ctrl     = reg_we && (reg_sel == SEL_CTRL);
   assign wr_stat     = reg_we && (reg_sel == SEL_STAT);
   assign wr_txd      = reg_we && (reg_sel == SEL_TXD);
   assign flush_pulse = wr_ctrl && reg_wdata[FLUSH_BIT];
   assign req_en      = ctrl_q.req_en;

   assign half_sel    = (ctrl_q.pack == PACK_LOW_HALF) ? reg_wdata[15:0] : reg_wdata[31:16];
   assign push_sample = half_sel[15 -: SAMPLE_W];

   assign free_cnt  = CW'(DEPTH) - fill;
   assign need      = ctrl_q.mono ? 2'd1 : 2'd2;
   assign pop_ok    = rate_strobe && (fill >= CW'(need));
   assign pop_n     = pop_ok ? need : 2'd0;
   assign under_set = rate_strobe && !pop_ok;

   dac_pf_rate_gen #(
      .CLK_HZ (CLK_HZ),
      .DIV_W  (DIV_W)
   ) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_code (ctrl_q.rate),
      .restart   (wr_ctrl),
      .strobe    (rate_strobe)
   );

   dac_pf_store #(
      .DEPTH (DEPTH),
      .W     (SAMPLE_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_pulse),
      .push      (wr_txd),
      .push_data (push_sample),
      .pop_n     (pop_n),
      .head0     (head0),
      .head1     (head1),
      .fill      (fill)
   );

   dac_pf_req #(
      .CW (CW)
   ) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_write  (wr_txd),
      .cfg_write (wr_ctrl),
      .strobe    (rate_strobe),
      .hold_cnt  (ctrl_q.hold_cnt),
      .req_en    (req_en),
      .trig      (ctrl_q.trig),
      .free_cnt  (free_cnt),
      .req       (dma_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         underrun_q <= 1'b0;
         dac_left   <= '0;
         dac_right  <= '0;
         dac_valid  <= 1'b0;
      end else begin
         dac_valid <= rate_strobe;
         if (wr_ctrl) begin
            ctrl_q <= ctrl_unpack(reg_wdata);
         end
         if (under_set) begin
            underrun_q <= 1'b1;
         end else if (wr_stat && reg_wdata[UNDER_BIT]) begin
            underrun_q <= 1'b0;
         end
         if (pop_ok) begin
            dac_left  <= head0;
            dac_right <= ctrl_q.mono ? head0 : head1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_CTRL: reg_rdata = ctrl_pack(ctrl_q);
         SEL_STAT: begin
            reg_rdata[UNDER_BIT]           = underrun_q;
            reg_rdata[FREE_LSB +: FREE_W]  = FREE_W'(free_cnt);
         end
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dac_play_fifo_chk.sv
module dac_play_fifo_chk #(
   parameter int DEPTH    = 64,
   parameter int CW       = 7,
   parameter int SAMPLE_W = 16
)(
   input logic                clk,
   input logic                rst_n,
   input logic                reg_we,
   input logic [1:0]          reg_sel,
   input logic                wd0,
   input logic                dma_req,
   input logic                req_en,
   input logic                underrun_q,
   input logic                rate_strobe,
   input logic [CW-1:0]       free_cnt,
   input logic [SAMPLE_W-1:0] dac_left,
   input logic [SAMPLE_W-1:0] dac_right
);

   // R9
   req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> req_en);

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= CW'(DEPTH));

   // R7
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(underrun_q) |-> $past(reg_we && (reg_sel == 2'd1) && wd0));

   // R6
   dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rate_strobe |=> ($stable(dac_left) && $stable(dac_right)));

   // R8
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && (reg_sel == 2'd0) && wd0) |=> (free_cnt == CW'(DEPTH)));

endmodule

bind dac_play_fifo dac_play_fifo_chk #(
   .DEPTH    (DEPTH),
   .CW       (CW),
   .SAMPLE_W (SAMPLE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_we      (reg_we),
   .reg_sel     (reg_sel),
   .wd0         (reg_wdata[0]),
   .dma_req     (dma_req),
   .req_en      (req_en),
   .underrun_q  (underrun_q),
   .rate_strobe (rate_strobe),
   .free_cnt    (free_cnt),
   .dac_left    (dac_left),
   .dac_right   (dac_right)
);

// File: tb/dac_play_fifo_test.sv
module dac_play_fifo_test;

   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] dac_left, dac_right;
   logic        dac_valid, dma_req;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dac_play_fifo uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .dac_left  (dac_left),
      .dac_right (dac_right),
      .dac_valid (dac_valid),
      .dma_req   (dma_req)
   );

   // behavioural reference state
   logic [15:0] q[$];
   int          m_rate = 0, m_pack = 0, m_cc = 0, m_trig = 0;
   bit          m_mono = 0, m_wide = 0, m_en = 0, m_under = 0, m_valid = 0;
   int          m_div = 0, m_hold = 0;
   logic [15:0] m_l = '0, m_r = '0;

   function automatic int period(input int code);
      int hz;
      case (code)
         0: hz = 48000;  1: hz = 32000;  2: hz = 24000;  3: hz = 16000;
         4: hz = 12000;  5: hz = 8000;   6: hz = 192000; default: hz = 96000;
      endcase
      return 24576000 / hz;
   endfunction

   function automatic bit m_req();
      return m_en && ((DEPTH - q.size()) >= m_trig) && (m_hold == 0);
   endfunction

   function automatic logic [31:0] m_rdata(input logic [1:0] sel);
      logic [31:0] w;
      w = '0;
      if (sel == 2'd0) begin
         w[31:29] = 3'(m_rate); w[25:24] = 2'(m_pack); w[22:21] = 2'(m_cc);
         w[14:8] = 7'(m_trig); w[6] = m_mono; w[5] = m_wide; w[4] = m_en;
      end else if (sel == 2'd1) begin
         w[22:16] = 7'(DEPTH - q.size()); w[0] = m_under;
      end
      return w;
   endfunction

   task automatic model_step();
      bit strobe, uset, full_b;
      int need;
      if (!rst_n) begin
         q.delete();
         m_rate = 0; m_pack = 0; m_cc = 0; m_trig = 0;
         m_mono = 0; m_wide = 0; m_en = 0; m_under = 0; m_valid = 0;
         m_div = 0; m_hold = 0; m_l = '0; m_r = '0;
         return;
      end
      strobe = (m_div == period(m_rate) - 1);
      full_b = (q.size() >= DEPTH);
      m_valid = strobe;
      uset = 0;
      if (strobe) begin
         need = m_mono ? 1 : 2;
         if (q.size() >= need) begin
            m_l = q.pop_front();
            m_r = m_mono ? m_l : q.pop_front();
         end else begin
            m_under = 1; uset = 1;
         end
         if (m_hold > 0) m_hold--;
      end
      m_div = strobe ? 0 : m_div + 1;
      if (reg_we) begin
         case (reg_sel)
            2'd0: begin
               m_rate = int'(reg_wdata[31:29]); m_pack = int'(reg_wdata[25:24]);
               m_cc = int'(reg_wdata[22:21]);   m_trig = int'(reg_wdata[14:8]);
               m_mono = reg_wdata[6]; m_wide = reg_wdata[5]; m_en = reg_wdata[4];
               m_div = 0; m_hold = 0;
               if (reg_wdata[0]) q.delete();
            end
            2'd1: if (reg_wdata[0] && !uset) m_under = 0;
            2'd2: begin
               if (!full_b) q.push_back((m_pack == 1) ? reg_wdata[15:0] : reg_wdata[31:16]);
               m_hold = m_cc + 1;
            end
            default: ;
         endcase
      end
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check("R5 dac_left model", 32'(dac_left), 32'(m_l));
      check("R5 dac_right model", 32'(dac_right), 32'(m_r));
      check("R3 dac_valid model", 32'(dac_valid), 32'(m_valid));
      check("R9 dma_req model", 32'(dma_req), 32'(m_req()));
      check("R11 reg_rdata model", reg_rdata, m_rdata(reg_sel));
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] data);
      reg_sel = sel;
      #1;
      data = reg_rdata;
   endtask

   task automatic wait_valid(output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while (!dac_valid && n < 5000);
   endtask

   initial begin : watchdog
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] r;
      int n;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd(2'd1, r); check("R1 status after reset", r, 32'h0040_0000);
      rd(2'd0, r); check("R1 control after reset", r, 32'h0);
      check("R1 outputs after reset", {dac_left, dac_right}, 32'h0);
      check("R1 dma_req after reset", 32'(dma_req), 32'h0);

      // 192 kHz, low-half packing, stereo, flush
      wr(2'd0, (32'd6 << 29) | (32'd1 << 24) | (32'd8 << 8) | 32'd1);
      for (int k = 1; k <= 6; k++) wr(2'd2, {16'hF000 + 16'(k), 16'(k) * 16'h1111});
      rd(2'd0, r); check("R2 control readback, flush reads 0", r, (32'd6 << 29) | (32'd1 << 24) | (32'd8 << 8));
      wait_valid(n);
      check("R3 first strobe at 128 cycles", 32'(n + 6), 32'd128);
      check("R4 R5 first stereo pair", {dac_left, dac_right}, 32'h1111_2222);
      wait_valid(n);
      check("R3 strobe spacing 192k", 32'(n), 32'd128);
      wait_valid(n);
      check("R5 third pair", {dac_left, dac_right}, 32'h5555_6666);
      wait_valid(n);
      rd(2'd1, r); check("R6 underrun set on empty strobe", r, 32'h0040_0001);
      check("R6 outputs hold", {dac_left, dac_right}, 32'h5555_6666);

      // R7 write-one-to-clear
      wr(2'd1, 32'h0);
      rd(2'd1, r); check("R7 zero write keeps flag", r, 32'h0040_0001);
      wr(2'd1, 32'h1);
      rd(2'd1, r); check("R7 one write clears flag", r, 32'h0040_0000);

      // 96 kHz, high-half packing, mono
      wr(2'd0, (32'd7 << 29) | (32'd1 << 6));
      wr(2'd2, 32'h1234_ABCD);
      wr(2'd2, 32'h5678_0000);
      wait_valid(n);
      check("R3 first strobe at 256 cycles", 32'(n + 2), 32'd256);
      check("R4 R5 mono duplicates high half", {dac_left, dac_right}, 32'h1234_1234);
      wait_valid(n);
      check("R5 mono second sample", {dac_left, dac_right}, 32'h5678_5678);

      // packing mode 3 takes high half
      wr(2'd0, (32'd6 << 29) | (32'd3 << 24) | (32'd1 << 6));
      wr(2'd2, 32'hBEEF_0001);
      wait_valid(n);
      check("R4 mode 3 uses high half", 32'(dac_left), 32'h0000_BEEF);

      // R8 flush
      for (int k = 0; k < 3; k++) wr(2'd2, 32'h0101_0101);
      wr(2'd0, (32'd5 << 29) | 32'd1);
      rd(2'd1, r); check("R8 flush frees all entries", 32'(r[22:16]), 32'd64);

      // R10 overfill at 8 kHz, then drain at 192 kHz
      for (int k = 0; k < 70; k++) wr(2'd2, {16'(k), 16'h0});
      rd(2'd1, r); check("R10 full FIFO free count", 32'(r[22:16]), 32'd0);
      wr(2'd0, 32'd6 << 29);
      for (int k = 0; k < 32; k++) wait_valid(n);
      check("R10 last stored pair is 62/63", {dac_left, dac_right}, {16'd62, 16'd63});
      rd(2'd1, r); check("R10 dropped writes left nothing", 32'(r[22:16]), 32'd64);

      // R9 request threshold and hold-off
      wr(2'd0, (32'd6 << 29) | (32'd1 << 21) | (32'd60 << 8) | (32'd1 << 4) | 32'd1);
      check("R9 request with room", 32'(dma_req), 32'd1);
      for (int k = 0; k < 5; k++) wr(2'd2, 32'h00AA_00AA);
      check("R9 request low below threshold", 32'(dma_req), 32'd0);
      wait_valid(n);
      check("R9 request held off one strobe", 32'(dma_req), 32'd0);
      wait_valid(n);
      check("R9 request after hold-off", 32'(dma_req), 32'd1);
      wr(2'd0, (32'd6 << 29) | (32'd64 << 8) | (32'd1 << 4) | 32'd1);
      check("R9 request at free equal threshold", 32'(dma_req), 32'd1);
      wr(2'd0, 32'h0);
      check("R9 zero control stops request", 32'(dma_req), 32'd0);
      repeat (4) tick();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule